// File: doc/BRIEF.md
# Two-Way Set-Associative Address Translation Buffer

This block keeps a small cache of recent page translations for a paged virtual memory system. A 32-bit effective address arrives on the lookup port. Its top four bits pick one of sixteen segment registers. That register's 24-bit segment identifier is joined to the remaining 28 address bits to form a 52-bit virtual address. The virtual page number of that address is then searched in a 64-entry, two-way set-associative array. On a hit the block returns a 32-bit physical address in the same cycle the address is presented.

On a miss the block only raises a flag. It never fetches page-table entries itself. Software handles the miss and writes the translation through a refill port, and the block picks the way to overwrite from a per-set least-recently-used bit. Supervisor software can drop all entries of one set by giving an effective address, or clear the whole array in a single cycle. Segment registers are loaded through their own write port.

Top module: `tlb_xlat`

## Requirements
- R1: After reset every entry is invalid, every LRU bit is 0 and every segment register is 0, so every lookup misses.
- R2: A lookup is combinational. On a hit, `lk_pa_o` is the stored 20-bit page frame joined with effective-address bits 11:0, in the same cycle.
- R3: The tag is the 24-bit segment identifier read from the register selected by effective-address bits 31:28, joined with bits 27:17. Two segment indices that hold the same identifier alias to the same entries.
- R4: Bits 16:12 select one of 32 sets. An address that differs from a stored one only in bits 27:17 misses.
- R5: With `lk_req_i` high, exactly one of `lk_hit_o` and `lk_miss_o` is 1. With `lk_req_i` low, both are 0. `lk_pa_o` is 0 whenever `lk_hit_o` is 0.
- R6: A refill writes the way named by the set's LRU bit (0 = way 0) and then sets that bit to the other way. Refill tags use the segment registers as they were before the write edge.
- R7: A lookup hit in way w sets the LRU bit of that set to the other way.
- R8: If both ways of a set match, way 0 supplies the translation and the hit counts as a way-0 hit for R7.
- R9: A selective invalidate clears both ways of the set given by `inv_ea_i` bits 16:12. It leaves all other sets and all LRU bits unchanged, and it takes effect at the next edge.
- R10: A global invalidate clears every valid bit in one cycle.
- R11: A refill in the same cycle as a global invalidate, or as a selective invalidate of the same set, is dropped: no entry is written and no LRU bit changes. A refill to a different set proceeds.
- R12: When a lookup hit and a refill target the same set in one cycle, the refill's LRU update wins. The lookup sees the contents from before the refill.
- R13: A segment register write takes effect at the next edge. A lookup or refill in the same cycle uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_req_i | input | 1 | Lookup request |
| lk_ea_i | input | 32 | Lookup effective address |
| lk_hit_o | output | 1 | Lookup hit |
| lk_miss_o | output | 1 | Lookup miss, software refill needed |
| lk_pa_o | output | 32 | Translated physical address |
| wr_en_i | input | 1 | Refill write strobe |
| wr_ea_i | input | 32 | Effective address of the refilled page |
| wr_ppn_i | input | 20 | Physical page frame to store |
| inv_en_i | input | 1 | Selective set invalidate |
| inv_ea_i | input | 32 | Effective address selecting the set to invalidate |
| inv_all_i | input | 1 | Global invalidate |
| sr_we_i | input | 1 | Segment register write strobe |
| sr_idx_i | input | 4 | Segment register index |
| sr_vsid_i | input | 24 | Segment identifier to write |

## Verification
Refill and invalidate can land in the same cycle. So can refill and a lookup hit to one set, where both want to change the LRU bit. A segment register write can also coincide with a lookup or refill that reads that register. The bench drives each pair in a single cycle and then judges the outcome with follow-up lookups. These show whether the dropped or kept entry is present, which way the next refill evicts, and whether old or new segment values were used. The bench compares every cycle's outputs against an arithmetic model built from the requirements, during sweeps over all 32 sets and both ways.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic {WAY0 = 1'b0, WAY1 = 1'b1} way_e;

  function automatic way_e other_way(way_e w);
    return (w == WAY0) ? WAY1 : WAY0;
  endfunction
endpackage

// File: rtl/tlb_segregs.sv
module tlb_segregs #(
  parameter int SEG_W  = 4,
  parameter int VSID_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEG_W-1:0]  widx_i,
  input  logic [VSID_W-1:0] wvsid_i,
  input  logic [SEG_W-1:0]  ridx_a_i,
  output logic [VSID_W-1:0] rvsid_a_o,
  input  logic [SEG_W-1:0]  ridx_b_i,
  output logic [VSID_W-1:0] rvsid_b_o
);
  localparam int SEG_CNT = 1 << SEG_W;

  logic [VSID_W-1:0] regs_q [SEG_CNT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SEG_CNT; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[widx_i] <= wvsid_i;
    end
  end

  assign rvsid_a_o = regs_q[ridx_a_i];
  assign rvsid_b_o = regs_q[ridx_b_i];
endmodule

// File: rtl/tlb_way.sv
module tlb_way #(
  parameter int SET_W = 5,
  parameter int TAG_W = 35,
  parameter int PPN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] lk_set_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             hit_o,
  output logic [PPN_W-1:0] ppn_o,
  input  logic             wr_en_i,
  input  logic [SET_W-1:0] wr_set_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [PPN_W-1:0] wr_ppn_i,
  input  logic             inv_set_en_i,
  input  logic [SET_W-1:0] inv_set_i,
  input  logic             inv_all_i
);
  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0]  valid_q;
  logic [TAG_W-1:0] tag_q [SETS];
  logic [PPN_W-1:0] ppn_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (inv_all_i) begin
      valid_q <= '0;
    end else begin
      if (wr_en_i)      valid_q[wr_set_i]  <= 1'b1;
      if (inv_set_en_i) valid_q[inv_set_i] <= 1'b0;
    end
  end

  // payload needs no reset, valid bit guards it
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_set_i] <= wr_tag_i;
      ppn_q[wr_set_i] <= wr_ppn_i;
    end
  end

  assign hit_o = valid_q[lk_set_i] && (tag_q[lk_set_i] == lk_tag_i);
  assign ppn_o = ppn_q[lk_set_i];
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int SET_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] vict_set_i,
  output logic             vict_o,
  input  logic             hit_upd_i,
  input  logic [SET_W-1:0] hit_set_i,
  input  logic             hit_val_i,
  input  logic             fill_upd_i,
  input  logic [SET_W-1:0] fill_set_i,
  input  logic             fill_val_i
);
  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0] lru_q;

  // fill update is last so it overrides a hit to the same set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lru_q <= '0;
    end else begin
      if (hit_upd_i)  lru_q[hit_set_i]  <= hit_val_i;
      if (fill_upd_i) lru_q[fill_set_i] <= fill_val_i;
    end
  end

  assign vict_o = lru_q[vict_set_i];
endmodule

// File: rtl/tlb_xlat.sv
module tlb_xlat #(
  parameter int EA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int SEG_W     = 4,
  parameter int VSID_W    = 24,
  parameter int SET_W     = 5,
  localparam int PPN_W    = PA_W - PAGE_BITS,
  localparam int HI_W     = EA_W - SEG_W - PAGE_BITS - SET_W,
  localparam int TAG_W    = VSID_W + HI_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_req_i,
  input  logic [EA_W-1:0]   lk_ea_i,
  output logic              lk_hit_o,
  output logic              lk_miss_o,
  output logic [PA_W-1:0]   lk_pa_o,
  input  logic              wr_en_i,
  input  logic [EA_W-1:0]   wr_ea_i,
  input  logic [PPN_W-1:0]  wr_ppn_i,
  input  logic              inv_en_i,
  input  logic [EA_W-1:0]   inv_ea_i,
  input  logic              inv_all_i,
  input  logic              sr_we_i,
  input  logic [SEG_W-1:0]  sr_idx_i,
  input  logic [VSID_W-1:0] sr_vsid_i
);
  import tlb_pkg::*;

  localparam int NWAYS = 2;
  localparam int SET_LO = PAGE_BITS;
  localparam int HI_LO  = PAGE_BITS + SET_W;

  logic [VSID_W-1:0] lk_vsid, wr_vsid;
  logic [SET_W-1:0]  lk_set, wr_set, inv_set;
  logic [TAG_W-1:0]  lk_tag, wr_tag;
  logic [NWAYS-1:0]  way_hit;
  logic [PPN_W-1:0]  way_ppn [NWAYS];
  logic              hit_any, wr_go, vict_bit;
  way_e              hit_way, victim;

  assign lk_set  = lk_ea_i[SET_LO +: SET_W];
  assign wr_set  = wr_ea_i[SET_LO +: SET_W];
  assign inv_set = inv_ea_i[SET_LO +: SET_W];

  tlb_segregs #(.SEG_W(SEG_W), .VSID_W(VSID_W)) u_seg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (sr_we_i),
    .widx_i    (sr_idx_i),
    .wvsid_i   (sr_vsid_i),
    .ridx_a_i  (lk_ea_i[EA_W-1 -: SEG_W]),
    .rvsid_a_o (lk_vsid),
    .ridx_b_i  (wr_ea_i[EA_W-1 -: SEG_W]),
    .rvsid_b_o (wr_vsid)
  );

  assign lk_tag = {lk_vsid, lk_ea_i[HI_LO +: HI_W]};
  assign wr_tag = {wr_vsid, wr_ea_i[HI_LO +: HI_W]};

  // invalidate of the target set beats refill
  assign wr_go  = wr_en_i && !(inv_all_i || (inv_en_i && (inv_set == wr_set)));
  assign victim = way_e'(vict_bit);

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    tlb_way #(.SET_W(SET_W), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_way (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .lk_set_i     (lk_set),
      .lk_tag_i     (lk_tag),
      .hit_o        (way_hit[w]),
      .ppn_o        (way_ppn[w]),
      .wr_en_i      (wr_go && (victim == way_e'(w))),
      .wr_set_i     (wr_set),
      .wr_tag_i     (wr_tag),
      .wr_ppn_i     (wr_ppn_i),
      .inv_set_en_i (inv_en_i),
      .inv_set_i    (inv_set),
      .inv_all_i    (inv_all_i)
    );
  end

  assign hit_any = |way_hit;
  assign hit_way = way_hit[0] ? WAY0 : WAY1;

  tlb_lru #(.SET_W(SET_W)) u_lru (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vict_set_i (wr_set),
    .vict_o     (vict_bit),
    .hit_upd_i  (lk_hit_o),
    .hit_set_i  (lk_set),
    .hit_val_i  (other_way(hit_way)),
    .fill_upd_i (wr_go),
    .fill_set_i (wr_set),
    .fill_val_i (other_way(victim))
  );

  assign lk_hit_o  = lk_req_i && hit_any;
  assign lk_miss_o = lk_req_i && !hit_any;
  assign lk_pa_o   = lk_hit_o ? {way_ppn[hit_way], lk_ea_i[PAGE_BITS-1:0]} : '0;
endmodule

// File: rtl/tlb_xlat_chk.sv
module tlb_xlat_chk #(
  parameter int EA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int SET_W     = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            lk_req_i,
  input logic [EA_W-1:0] lk_ea_i,
  input logic            lk_hit_o,
  input logic            lk_miss_o,
  input logic [PA_W-1:0] lk_pa_o,
  input logic            inv_en_i,
  input logic [EA_W-1:0] inv_ea_i,
  input logic            inv_all_i
);
  assert_req_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_req_i |-> $countones({lk_hit_o, lk_miss_o}) == 1);

  assert_idle_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_req_i |-> !lk_hit_o && !lk_miss_o);

  assert_pa_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> lk_pa_o == '0);

  assert_offset_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> lk_pa_o[PAGE_BITS-1:0] == lk_ea_i[PAGE_BITS-1:0]);

  assert_global_inv_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_all_i |=> !lk_hit_o);

  assert_set_inv_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_en_i |=> !(lk_hit_o &&
      lk_ea_i[PAGE_BITS +: SET_W] == $past(inv_ea_i[PAGE_BITS +: SET_W])));
endmodule

bind tlb_xlat tlb_xlat_chk #(
  .EA_W(EA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .SET_W(SET_W)
) u_chk (.*);

// File: tb/tb_tlb_xlat.sv
module tb_tlb_xlat;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lk_req_i = 1'b0;
  logic [31:0] lk_ea_i = '0;
  logic        lk_hit_o, lk_miss_o;
  logic [31:0] lk_pa_o;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_ea_i = '0;
  logic [19:0] wr_ppn_i = '0;
  logic        inv_en_i = 1'b0;
  logic [31:0] inv_ea_i = '0;
  logic        inv_all_i = 1'b0;
  logic        sr_we_i = 1'b0;
  logic [3:0]  sr_idx_i = '0;
  logic [23:0] sr_vsid_i = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  tlb_xlat dut (.*);

  // reference state derived from the requirements
  logic        mv [2][32];
  logic [34:0] mt [2][32];
  logic [19:0] mp [2][32];
  logic        ml [32];
  logic [23:0] mseg [16];

  function automatic logic [31:0] mk_ea(int seg, int hi, int set, int off);
    return {4'(seg), 11'(hi), 5'(set), 12'(off)};
  endfunction

  function automatic logic [34:0] mk_tag(logic [31:0] ea);
    return {mseg[ea[31:28]], ea[27:17]};
  endfunction

  task automatic cyc(input logic req, input logic [31:0] lea,
                     input logic we, input logic [31:0] wea, input logic [19:0] ppn,
                     input logic inv, input logic [31:0] iea, input logic iall,
                     input logic swe, input logic [3:0] sidx, input logic [23:0] sv,
                     input string rq);
    logic h0, h1, eh, v;
    logic [4:0] s, ws;
    logic [31:0] epa;
    logic [34:0] wtag;
    lk_req_i = req; lk_ea_i = lea; wr_en_i = we; wr_ea_i = wea; wr_ppn_i = ppn;
    inv_en_i = inv; inv_ea_i = iea; inv_all_i = iall;
    sr_we_i = swe; sr_idx_i = sidx; sr_vsid_i = sv;
    #5;
    s = lea[16:12];
    h0 = mv[0][s] && mt[0][s] == mk_tag(lea);
    h1 = mv[1][s] && mt[1][s] == mk_tag(lea);
    eh = req && (h0 || h1);
    epa = eh ? {(h0 ? mp[0][s] : mp[1][s]), lea[11:0]} : 32'h0;
    checks++;
    if (lk_hit_o !== eh || lk_miss_o !== (req && !eh) || lk_pa_o !== epa) begin
      errors++;
      $display("FAIL %s ea=%h hit/miss/pa=%b/%b/%h expected %b/%b/%h",
               rq, lea, lk_hit_o, lk_miss_o, lk_pa_o, eh, req && !eh, epa);
    end
    ws = wea[16:12];
    v = ml[ws];
    wtag = mk_tag(wea);
    @(posedge clk_i);
    if (eh) ml[s] = h0 ? 1'b1 : 1'b0;
    if (we && !(iall || (inv && iea[16:12] == ws))) begin
      mv[v][ws] = 1'b1; mt[v][ws] = wtag; mp[v][ws] = ppn;
      ml[ws] = ~v;
    end
    if (inv) begin mv[0][iea[16:12]] = 1'b0; mv[1][iea[16:12]] = 1'b0; end
    if (iall) for (int i = 0; i < 32; i++) begin mv[0][i] = 1'b0; mv[1][i] = 1'b0; end
    if (swe) mseg[sidx] = sv;
    #1;
  endtask

  task automatic look(input logic [31:0] ea, input string rq);
    cyc(1, ea, 0, 0, 0, 0, 0, 0, 0, 0, 0, rq);
  endtask
  task automatic fill(input logic [31:0] ea, input logic [19:0] ppn, input string rq);
    cyc(0, 0, 1, ea, ppn, 0, 0, 0, 0, 0, 0, rq);
  endtask
  task automatic seg_wr(input int idx, input logic [23:0] vs, input string rq);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 4'(idx), vs, rq);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      mv[0][i] = 0; mv[1][i] = 0; ml[i] = 0;
      mt[0][i] = '0; mt[1][i] = '0; mp[0][i] = '0; mp[1][i] = '0;
    end
    for (int i = 0; i < 16; i++) mseg[i] = '0;
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1: empty after reset
    for (int s = 0; s < 32; s++) look(mk_ea(s % 16, s * 3, s, s), "R1");

    // R13: segment write with lookup and refill reading old value
    cyc(1, mk_ea(1, 2, 3, 4), 1, mk_ea(1, 2, 3, 0), 20'h11111, 0, 0, 0,
        1, 4'd1, 24'hABCDEF, "R13");
    look(mk_ea(1, 2, 3, 4), "R13");
    for (int i = 0; i < 16; i++) seg_wr(i, 24'h400000 + 24'(i * 4099), "R3");
    look(mk_ea(1, 2, 3, 4), "R3");

    // R6: fill every set in both ways
    for (int s = 0; s < 32; s++)
      for (int w = 0; w < 2; w++)
        fill(mk_ea(s % 16, s * 5 + w, s, 0), 20'(s * 64 + w * 7 + 20'h80000), "R6");
    // R2/R7: look up all 64 entries with varying offsets
    for (int s = 0; s < 32; s++)
      for (int w = 0; w < 2; w++)
        look(mk_ea(s % 16, s * 5 + w, s, s * 37 + w * 11), "R2");
    // R4: only bits 27:17 differ
    for (int s = 0; s < 32; s++) look(mk_ea(s % 16, s * 5 + 2, s, 0), "R4");
    // R5: idle lookup of a present address
    cyc(0, mk_ea(0, 0, 0, 0), 0, 0, 0, 0, 0, 0, 0, 0, 0, "R5");

    // R6/R7: replacement order in set 3
    look(mk_ea(3, 15, 3, 0), "R7");
    fill(mk_ea(3, 100, 3, 0), 20'h0AAAA, "R6");
    look(mk_ea(3, 16, 3, 0), "R6");
    look(mk_ea(3, 15, 3, 0), "R7");
    look(mk_ea(3, 100, 3, 0), "R6");
    fill(mk_ea(3, 101, 3, 0), 20'h0BBBB, "R6");
    look(mk_ea(3, 15, 3, 0), "R7");
    look(mk_ea(3, 100, 3, 0), "R6");

    // R8: duplicate tag in both ways
    cyc(0, 0, 0, 0, 0, 1, mk_ea(0, 0, 9, 0), 0, 0, 0, 0, "R9");
    look(mk_ea(9, 45, 9, 0), "R9");
    fill(mk_ea(9, 300, 9, 0), 20'h12345, "R8");
    fill(mk_ea(9, 300, 9, 0), 20'h54321, "R8");
    look(mk_ea(9, 300, 9, 8), "R8");
    fill(mk_ea(9, 301, 9, 0), 20'h0CCCC, "R8");
    look(mk_ea(9, 300, 9, 8), "R8");
    look(mk_ea(9, 301, 9, 8), "R8");

    // R9: selective invalidate spares neighbours
    cyc(0, 0, 0, 0, 0, 1, mk_ea(7, 7, 4, 5), 0, 0, 0, 0, "R9");
    look(mk_ea(4, 20, 4, 0), "R9");
    look(mk_ea(4, 21, 4, 0), "R9");
    look(mk_ea(5, 25, 5, 0), "R9");
    fill(mk_ea(4, 22, 4, 0), 20'h0DDDD, "R9");
    look(mk_ea(4, 22, 4, 0), "R9");

    // R11: refill against invalidate in the same cycle
    cyc(0, 0, 1, mk_ea(6, 200, 6, 0), 20'h0EEEE, 1, mk_ea(0, 0, 6, 0), 0, 0, 0, 0, "R11");
    look(mk_ea(6, 200, 6, 0), "R11");
    fill(mk_ea(6, 201, 6, 0), 20'h0F0F0, "R11");
    look(mk_ea(6, 201, 6, 0), "R11");
    cyc(0, 0, 1, mk_ea(7, 202, 7, 0), 20'h01234, 1, mk_ea(0, 0, 8, 0), 0, 0, 0, 0, "R11");
    look(mk_ea(7, 202, 7, 0), "R11");
    look(mk_ea(8, 40, 8, 0), "R11");

    // R12: hit and refill on one set together
    cyc(1, mk_ea(10, 50, 10, 3), 1, mk_ea(10, 400, 10, 0), 20'h0ABAB,
        0, 0, 0, 0, 0, 0, "R12");
    look(mk_ea(10, 400, 10, 0), "R12");
    fill(mk_ea(10, 401, 10, 0), 20'h0CDCD, "R12");
    look(mk_ea(10, 50, 10, 0), "R12");
    look(mk_ea(10, 51, 10, 0), "R12");
    look(mk_ea(10, 401, 10, 0), "R12");

    // R3: alias segment 7 onto segment 2
    seg_wr(7, mseg[2], "R3");
    look(mk_ea(7, 10, 2, 0), "R3");
    look(mk_ea(7, 35, 7, 0), "R3");

    // R10: global invalidate with a refill in the same cycle
    cyc(1, mk_ea(2, 10, 2, 0), 1, mk_ea(12, 500, 12, 0), 20'h0FEED, 0, 0, 1, 0, 0, 0, "R10");
    for (int s = 0; s < 32; s++)
      for (int w = 0; w < 2; w++) look(mk_ea(s % 16, s * 5 + w, s, 0), "R10");
    look(mk_ea(12, 500, 12, 0), "R11");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish, actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule